// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block sits beside an interrupt arbiter. It serves two kinds of access from each CPU: a read that acknowledges an interrupt, and a write that completes one. An acknowledge takes the arbiter's current candidate for that CPU. If the candidate is more urgent than what the CPU is already running, it becomes the running interrupt. The interrupt that was running is recorded as its predecessor, so nested interrupts form a linked chain for each CPU. The block also emits one-cycle pulses that clear or set pending bits held elsewhere.

A completion normally names the running interrupt. In that case the predecessor is restored in the same cycle. A completion may also name an interrupt deeper in the chain. The block then walks the chain one link per clock and splices the named entry out, and the running state stays as it is. While the walk is in progress, `busy` is high and any new access is discarded.

A lower priority value means a more urgent interrupt. The ID 1023 (all ones in the ID field) means "none".

Top module: `intr_ack_eoi`

## Requirements
- R1: After reset, every CPU's running ID is 1023 and its running priority is 0x100; `busy`, `rd_valid`, `pend_set` and `pend_clr` are all zero.
- R2: An accepted acknowledge returns ID 1023 with `rd_valid` high one cycle later and changes no state when any of the following holds:
  - the CPU's candidate ID is 1023;
  - the candidate ID is not below NUM_IRQ;
  - the candidate's priority is greater than or equal to the CPU's running priority.
- R3: A granted acknowledge returns the candidate ID. The running ID then becomes that ID and the running priority becomes its 8-bit priority zero-extended. The old running ID is stored as the new ID's predecessor link.
- R4: On a granted acknowledge, `pend_clr` pulses the bit at index cpu*NUM_IRQ+id for every CPU when the ID's `one_of_n` bit is 1. When that bit is 0, it pulses only the acknowledging CPU's bit.
- R5: A completion takes its ID from `acc_wdata[9:0]` and ignores the higher bits. IDs not below NUM_IRQ, which includes 1023, have no effect.
- R6: A completion has no effect on the running state when the CPU's running ID is 1023.
- R7: A completion pulses `pend_set` at bit cpu*NUM_IRQ+id when all of the following hold:
  - the ID's `edge_mode` bit is 0 (level);
  - the ID is enabled for this CPU;
  - its `line_level` is high;
  - this CPU's bit is set in `target_map`.
  Otherwise `pend_set` stays zero.
- R8: A completion of the running ID makes its predecessor link the running ID one cycle later. The running priority becomes that link's priority, or 0x100 if the link is 1023.
- R9: A completion of a non-running ID walks the chain from the running ID, one link per cycle, with `busy` high, until a link equals the named ID. That link is replaced by the named ID's own link. The running ID and running priority do not change.
- R10: An access presented while `busy` is high is discarded: no `rd_valid`, no pulse and no state change.
- R11: An access on one CPU leaves the other CPUs' running IDs and running priorities unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 0 = acknowledge read, 1 = completion write |
| acc_cpu | input | CPU_W | CPU issuing the access |
| acc_wdata | input | 32 | Completion data; ID in bits [9:0] |
| pend_id | input | NUM_CPU*ID_W | Arbiter's highest pending ID per CPU |
| prio_tbl | input | NUM_IRQ*PRIO_W | Priority of each ID |
| edge_mode | input | NUM_IRQ | 1 = edge triggered, 0 = level |
| one_of_n | input | NUM_IRQ | 1 = acknowledge clears pending on all CPUs |
| line_level | input | NUM_IRQ | Current input line level |
| enable_map | input | NUM_CPU*NUM_IRQ | Enable per CPU and ID |
| target_map | input | NUM_CPU*NUM_IRQ | Target per CPU and ID |
| busy | output | 1 | Chain walk in progress |
| rd_valid | output | 1 | Acknowledge result valid |
| rd_id | output | ID_W | Acknowledged ID or 1023 |
| run_id | output | NUM_CPU*ID_W | Running ID per CPU |
| run_prio | output | NUM_CPU*(PRIO_W+1) | Running priority per CPU |
| pend_set | output | NUM_CPU*NUM_IRQ | One-cycle pending set pulses |
| pend_clr | output | NUM_CPU*NUM_IRQ | One-cycle pending clear pulses |

## Verification
The hardest state to reach is a chain at least three deep in which an inner entry is completed while the outer one keeps running. The stimulus builds it by acknowledging three IDs in order of rising urgency. It then completes the oldest one and watches `busy` for exactly as many cycles as there are hops. An acknowledge is pushed in during the walk, and the bench confirms it is dropped. Completing the remaining entries in order then shows that the spliced link skips the removed ID.

// File: rtl/intr_ae_pkg.sv
package intr_ae_pkg;
   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_HOP  = 1'b1
   } walk_state_e;

   // index width that stays at least one bit for a single-entry range
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/intr_link_store.sv
module intr_link_store
   import intr_ae_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 32,
   parameter int ID_W    = 10,
   localparam int CPU_W  = idx_w(NUM_CPU),
   localparam int IDX_W  = idx_w(NUM_IRQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CPU_W-1:0] a_cpu,
   input  logic [ID_W-1:0]  a_id,
   output logic [ID_W-1:0]  a_q,
   input  logic [CPU_W-1:0] b_cpu,
   input  logic [ID_W-1:0]  b_id,
   output logic [ID_W-1:0]  b_q,
   input  logic             wr_en,
   input  logic [CPU_W-1:0] wr_cpu,
   input  logic [ID_W-1:0]  wr_id,
   input  logic [ID_W-1:0]  wr_d
);
   localparam logic [ID_W-1:0] NONE  = '1;
   localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

   logic [ID_W-1:0] link_q [NUM_CPU][NUM_IRQ];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CPU; c++)
            for (int i = 0; i < NUM_IRQ; i++)
               link_q[c][i] <= NONE;
      end else if (wr_en && (wr_id < LIMIT)) begin
         link_q[wr_cpu][wr_id[IDX_W-1:0]] <= wr_d;
      end
   end

   assign a_q = (a_id < LIMIT) ? link_q[a_cpu][a_id[IDX_W-1:0]] : NONE;
   assign b_q = (b_id < LIMIT) ? link_q[b_cpu][b_id[IDX_W-1:0]] : NONE;
endmodule

// File: rtl/intr_chain_walk.sv
module intr_chain_walk
   import intr_ae_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int ID_W    = 10,
   localparam int CPU_W  = idx_w(NUM_CPU)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CPU_W-1:0] start_cpu,
   input  logic [ID_W-1:0]  start_head,
   input  logic [ID_W-1:0]  start_tgt,
   input  logic [ID_W-1:0]  hop_q,
   input  logic [ID_W-1:0]  tgt_link,
   output logic             busy,
   output logic [CPU_W-1:0] cur_cpu,
   output logic [ID_W-1:0]  cur_id,
   output logic [ID_W-1:0]  tgt_id,
   output logic             fix_en,
   output logic [ID_W-1:0]  fix_d
);
   localparam logic [ID_W-1:0] NONE = '1;

   walk_state_e      state_q;
   logic [CPU_W-1:0] cpu_q;
   logic [ID_W-1:0]  cur_q;
   logic [ID_W-1:0]  tgt_q;
   logic             hit;
   logic             dead_end;

   always_comb begin
      hit      = (state_q == WALK_HOP) && (hop_q == tgt_q);
      dead_end = (state_q == WALK_HOP) && (hop_q == NONE);
      fix_en   = hit;
      fix_d    = tgt_link;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WALK_IDLE;
         cpu_q   <= '0;
         cur_q   <= NONE;
         tgt_q   <= NONE;
      end else begin
         unique case (state_q)
            WALK_IDLE: if (start) begin
               state_q <= WALK_HOP;
               cpu_q   <= start_cpu;
               cur_q   <= start_head;
               tgt_q   <= start_tgt;
            end
            WALK_HOP: begin
               if (hit || dead_end) state_q <= WALK_IDLE;
               else                 cur_q   <= hop_q;
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign busy    = (state_q == WALK_HOP);
   assign cur_cpu = cpu_q;
   assign cur_id  = cur_q;
   assign tgt_id  = tgt_q;
endmodule

// File: rtl/intr_ack_eoi.sv
module intr_ack_eoi
   import intr_ae_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 32,
   parameter int ID_W    = 10,
   parameter int PRIO_W  = 8,
   localparam int CPU_W  = idx_w(NUM_CPU),
   localparam int RP_W   = PRIO_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_valid,
   input  logic                       acc_write,
   input  logic [CPU_W-1:0]           acc_cpu,
   input  logic [31:0]                acc_wdata,
   input  logic [NUM_CPU*ID_W-1:0]    pend_id,
   input  logic [NUM_IRQ*PRIO_W-1:0]  prio_tbl,
   input  logic [NUM_IRQ-1:0]         edge_mode,
   input  logic [NUM_IRQ-1:0]         one_of_n,
   input  logic [NUM_IRQ-1:0]         line_level,
   input  logic [NUM_CPU*NUM_IRQ-1:0] enable_map,
   input  logic [NUM_CPU*NUM_IRQ-1:0] target_map,
   output logic                       busy,
   output logic                       rd_valid,
   output logic [ID_W-1:0]            rd_id,
   output logic [NUM_CPU*ID_W-1:0]    run_id,
   output logic [NUM_CPU*RP_W-1:0]    run_prio,
   output logic [NUM_CPU*NUM_IRQ-1:0] pend_set,
   output logic [NUM_CPU*NUM_IRQ-1:0] pend_clr
);
   localparam int              IDX_W = idx_w(NUM_IRQ);
   localparam logic [ID_W-1:0] NONE  = '1;
   localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);
   localparam logic [RP_W-1:0] IDLE_PRIO = RP_W'(1) << PRIO_W;

   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1..8");
   end
   if (NUM_IRQ < 2 || NUM_IRQ > (1 << ID_W) - 4) begin : g_bad_irq
      $error("NUM_IRQ must leave the all-ones ID unimplemented");
   end
   if (ID_W < 2 || ID_W > 16 || IDX_W > ID_W) begin : g_bad_id
      $error("ID_W out of range");
   end

   logic [ID_W-1:0] run_id_q   [NUM_CPU];
   logic [RP_W-1:0] run_prio_q [NUM_CPU];

   function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
      return prio_tbl[int'(id[IDX_W-1:0])*PRIO_W +: PRIO_W];
   endfunction

   // access decode
   logic             accept, do_ack, do_eoi;
   logic [ID_W-1:0]  cur_run, cand, eoi_id, restore;
   logic [PRIO_W-1:0] cand_prio;
   logic             grant, eoi_ok, eoi_inorder, eoi_deep, retrig;
   int               cand_bit, eoi_bit;

   // link store and walker wiring
   logic             w_busy, w_fix;
   logic [CPU_W-1:0] w_cpu;
   logic [ID_W-1:0]  w_cur, w_tgt, w_fix_d, hop_q, a_q;
   logic [CPU_W-1:0] a_cpu, wr_cpu;
   logic [ID_W-1:0]  a_id, wr_id, wr_d;
   logic             wr_en;

   always_comb begin
      accept      = acc_valid && !w_busy;
      do_ack      = accept && !acc_write;
      do_eoi      = accept && acc_write;
      cur_run     = run_id_q[acc_cpu];
      cand        = pend_id[int'(acc_cpu)*ID_W +: ID_W];
      cand_prio   = prio_of(cand);
      grant       = (cand < LIMIT) && ({1'b0, cand_prio} < run_prio_q[acc_cpu]);
      cand_bit    = int'(acc_cpu)*NUM_IRQ + int'(cand[IDX_W-1:0]);
      eoi_id      = acc_wdata[ID_W-1:0];
      eoi_bit     = int'(acc_cpu)*NUM_IRQ + int'(eoi_id[IDX_W-1:0]);
      eoi_ok      = (eoi_id < LIMIT) && (cur_run != NONE);
      eoi_inorder = eoi_ok && (eoi_id == cur_run);
      eoi_deep    = eoi_ok && (eoi_id != cur_run);
      retrig      = eoi_ok && !edge_mode[eoi_id[IDX_W-1:0]]
                    && line_level[eoi_id[IDX_W-1:0]]
                    && enable_map[eoi_bit] && target_map[eoi_bit];
      a_cpu       = w_busy ? w_cpu : acc_cpu;
      a_id        = w_busy ? w_tgt : eoi_id;
      restore     = a_q;
      if (w_fix) begin
         wr_en = 1'b1; wr_cpu = w_cpu;   wr_id = w_cur; wr_d = w_fix_d;
      end else begin
         wr_en = do_ack && grant;
         wr_cpu = acc_cpu; wr_id = cand; wr_d = cur_run;
      end
   end

   intr_link_store #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) links_i (
      .clk(clk), .rst_n(rst_n),
      .a_cpu(a_cpu), .a_id(a_id), .a_q(a_q),
      .b_cpu(w_cpu), .b_id(w_cur), .b_q(hop_q),
      .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_id(wr_id), .wr_d(wr_d)
   );

   intr_chain_walk #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) walk_i (
      .clk(clk), .rst_n(rst_n),
      .start(do_eoi && eoi_deep), .start_cpu(acc_cpu),
      .start_head(cur_run), .start_tgt(eoi_id),
      .hop_q(hop_q), .tgt_link(a_q),
      .busy(w_busy), .cur_cpu(w_cpu), .cur_id(w_cur), .tgt_id(w_tgt),
      .fix_en(w_fix), .fix_d(w_fix_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CPU; c++) begin
            run_id_q[c]   <= NONE;
            run_prio_q[c] <= IDLE_PRIO;
         end
         rd_valid <= 1'b0;
         rd_id    <= NONE;
         pend_set <= '0;
         pend_clr <= '0;
      end else begin
         rd_valid <= 1'b0;
         pend_set <= '0;
         pend_clr <= '0;
         if (do_ack) begin
            rd_valid <= 1'b1;
            rd_id    <= grant ? cand : NONE;
            if (grant) begin
               run_id_q[acc_cpu]   <= cand;
               run_prio_q[acc_cpu] <= {1'b0, cand_prio};
               if (one_of_n[cand[IDX_W-1:0]]) begin
                  for (int c = 0; c < NUM_CPU; c++)
                     pend_clr[c*NUM_IRQ + int'(cand[IDX_W-1:0])] <= 1'b1;
               end else begin
                  pend_clr[cand_bit] <= 1'b1;
               end
            end
         end
         if (do_eoi) begin
            if (retrig) pend_set[eoi_bit] <= 1'b1;
            if (eoi_inorder) begin
               run_id_q[acc_cpu]   <= restore;
               run_prio_q[acc_cpu] <= (restore == NONE) ? IDLE_PRIO
                                                        : {1'b0, prio_of(restore)};
            end
         end
      end
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_pack
      assign run_id[c*ID_W +: ID_W]   = run_id_q[c];
      assign run_prio[c*RP_W +: RP_W] = run_prio_q[c];
   end

   assign busy = w_busy;
endmodule

// File: rtl/intr_ack_eoi_chk.sv
module intr_ack_eoi_chk
   import intr_ae_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 32,
   parameter int ID_W    = 10,
   parameter int PRIO_W  = 8,
   localparam int CPU_W  = idx_w(NUM_CPU),
   localparam int RP_W   = PRIO_W + 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [CPU_W-1:0]           acc_cpu,
   input logic                       busy,
   input logic                       rd_valid,
   input logic [ID_W-1:0]            rd_id,
   input logic [NUM_CPU*ID_W-1:0]    run_id,
   input logic [NUM_CPU*RP_W-1:0]    run_prio,
   input logic [NUM_CPU*NUM_IRQ-1:0] pend_set,
   input logic [NUM_CPU*NUM_IRQ-1:0] pend_clr
);
   localparam logic [ID_W-1:0] NONE      = '1;
   localparam logic [RP_W-1:0] IDLE_PRIO = RP_W'(1) << PRIO_W;

   // R2: a refused acknowledge leaves every running state untouched
   a_r2_refusal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_id == NONE) |-> (run_id == $past(run_id) && run_prio == $past(run_prio)));

   // R10: nothing is accepted while the walk runs
   a_r10_busy_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!rd_valid && pend_clr == '0 && pend_set == '0));

   // R9: the walk never disturbs the running state
   a_r9_walk_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(run_id) && $stable(run_prio)));

   // R7: set and clear pulses come from different access kinds
   a_r7_set_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set != '0) |-> (pend_clr == '0));

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      // R3: a granted ID becomes the running ID of the CPU that read it
      a_r3_grant_runs: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_valid && rd_id != NONE && $past(acc_cpu) == CPU_W'(c))
            |-> (run_id[c*ID_W +: ID_W] == rd_id));
      // R8: an idle CPU always carries the idle priority
      a_r8_idle_pairing: assert property (@(posedge clk) disable iff (!rst_n)
         (run_id[c*ID_W +: ID_W] == NONE) |-> (run_prio[c*RP_W +: RP_W] == IDLE_PRIO));
   end
endmodule

bind intr_ack_eoi intr_ack_eoi_chk #(
   .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .PRIO_W(PRIO_W)
) chk_i (.*);

// File: tb/intr_ack_eoi_tb_top.sv
module intr_ack_eoi_tb_top;
   localparam int NC = 2;
   localparam int NI = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0, acc_write = 1'b0;
   logic [0:0]    acc_cpu = '0;
   logic [31:0]   acc_wdata = '0;
   logic [19:0]   pend_id = '1;
   logic [255:0]  prio_tbl;
   logic [31:0]   edge_mode = '0, one_of_n = '0, line_level = '0;
   logic [63:0]   enable_map = '0, target_map = '0;
   logic          busy, rd_valid;
   logic [9:0]    rd_id;
   logic [19:0]   run_id;
   logic [17:0]   run_prio;
   logic [63:0]   pend_set, pend_clr;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   intr_ack_eoi #(.NUM_CPU(NC), .NUM_IRQ(NI)) dut_i (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] run_of(input int c);
      return run_id[c*10 +: 10];
   endfunction
   function automatic logic [8:0] prio_run(input int c);
      return run_prio[c*9 +: 9];
   endfunction

   task automatic access(input bit wr, input int c, input logic [31:0] v);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_cpu = 1'(c); acc_wdata = v;
      if (!wr) pend_id[c*10 +: 10] = v[9:0];
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // table: op (0 acknowledge, 1 completion), cpu, value, expected read, run, prio
   localparam int NV = 13;
   localparam int          T_OP  [NV] = '{0,0,0,0,0,0,0,1,1,1,1,1,1};
   localparam int          T_CPU [NV] = '{0,0,0,0,0,0,1,0,0,0,0,0,1};
   localparam logic [31:0] T_VAL [NV] = '{1023,40,5,3,5,10,20,32'hFFFF_FC0A,1023,33,5,5,20};
   localparam int          T_RD  [NV] = '{1023,1023,5,1023,1023,10,20,0,0,0,0,0,0};
   localparam int          T_RUN [NV] = '{1023,1023,5,5,5,10,20,5,5,5,1023,1023,1023};
   localparam int          T_PRI [NV] = '{256,256,215,215,215,175,95,215,215,215,256,256,256};
   localparam string       T_REQ [NV] = '{"R2","R2","R3","R2","R2","R3","R3",
                                          "R5","R5","R5","R8","R6","R8"};

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NI; i++) prio_tbl[i*8 +: 8] = 8'(255 - 8*i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 run_id", 64'(run_id), 64'hFFFFF);
      check("R1 run_prio", 64'(run_prio), {46'd0, 9'h100, 9'h100});
      check("R1 busy/rd_valid", {62'd0, busy, rd_valid}, 64'd0);
      check("R1 pend pulses", pend_set | pend_clr, 64'd0);

      for (int k = 0; k < NV; k++) begin
         access(T_OP[k] != 0, T_CPU[k], T_VAL[k]);
         if (T_OP[k] == 0) begin
            check({T_REQ[k], " rd_valid"}, 64'(rd_valid), 64'd1);
            check({T_REQ[k], " rd_id"}, 64'(rd_id), 64'(T_RD[k]));
         end
         check({T_REQ[k], " run"}, 64'(run_of(T_CPU[k])), 64'(T_RUN[k]));
         check({T_REQ[k], " prio"}, 64'(prio_run(T_CPU[k])), 64'(T_PRI[k]));
      end

      // R4 one-of-N clears every CPU, otherwise only the reader
      one_of_n[7] = 1'b1;
      access(0, 0, 7);
      check("R4 1:N clear", pend_clr, (64'd1 << 7) | (64'd1 << 39));
      access(1, 0, 7);
      access(0, 0, 5);
      access(0, 1, 9);
      check("R4 own clear", pend_clr, 64'd1 << 41);
      check("R11 cpu0 run kept", 64'(run_of(0)), 64'd5);
      check("R11 cpu0 prio kept", 64'(prio_run(0)), 64'd215);
      check("R11 cpu1 run", 64'(run_of(1)), 64'd9);
      access(1, 1, 9);
      check("R11 cpu0 after cpu1 completion", 64'(run_of(0)), 64'd5);
      access(1, 0, 5);

      // R7 level re-pend on completion
      line_level[12] = 1'b1; enable_map[12] = 1'b1; target_map[12] = 1'b1;
      access(0, 0, 12);
      access(1, 0, 12);
      check("R7 level re-pend", pend_set, 64'd1 << 12);
      edge_mode[12] = 1'b1;
      access(0, 0, 12);
      access(1, 0, 12);
      check("R7 edge no re-pend", pend_set, 64'd0);
      edge_mode[12] = 1'b0; target_map[12] = 1'b0;
      access(0, 0, 12);
      access(1, 0, 12);
      check("R7 untargeted no re-pend", pend_set, 64'd0);
      check("R7 chain empty", 64'(run_of(0)), 64'd1023);

      // R9 two-hop out-of-order completion, R10 access during walk
      access(0, 0, 2);
      access(0, 0, 6);
      access(0, 0, 11);
      access(1, 0, 2);
      check("R9 busy hop1", 64'(busy), 64'd1);
      check("R9 run kept", 64'(run_of(0)), 64'd11);
      acc_valid = 1'b1; acc_write = 1'b0; acc_cpu = 1'b0; pend_id[9:0] = 10'd20;
      @(negedge clk);
      acc_valid = 1'b0;
      check("R10 dropped read", 64'(rd_valid), 64'd0);
      check("R9 busy hop2", 64'(busy), 64'd1);
      @(negedge clk);
      check("R9 walk done", 64'(busy), 64'd0);
      check("R10 run unchanged", 64'(run_of(0)), 64'd11);
      check("R9 prio kept", 64'(prio_run(0)), 64'd167);
      access(1, 0, 11);
      check("R9 restore 6", 64'(run_of(0)), 64'd6);
      check("R9 restore prio", 64'(prio_run(0)), 64'd207);
      access(1, 0, 6);
      check("R9 unlinked", 64'(run_of(0)), 64'd1023);
      check("R9 idle prio", 64'(prio_run(0)), 64'd256);

      // R9 one-hop case
      access(0, 0, 2);
      access(0, 0, 6);
      access(1, 0, 2);
      check("R9 one hop busy", 64'(busy), 64'd1);
      @(negedge clk);
      check("R9 one hop done", 64'(busy), 64'd0);
      access(1, 0, 6);
      check("R9 one hop unlinked", 64'(run_of(0)), 64'd1023);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule